// File: doc/BRIEF.md
# Asynchronous Receive Event Detector

This block sits behind an asynchronous serial receiver. It looks at each received character and at the sampled receive line, and it keeps four sticky interrupt status bits. The four events are a flow-resume character match, a line break, the end of that break, and a block-terminating character match.

A flow-resume or flow-stop character match can also switch the transmit flow-control state when in-band flow control is enabled. A block-terminating character produces a one-cycle marker strobe. Logic further down the receive path places this marker in the data stream so that the current receive buffer gets closed.

The break detector counts bit-time ticks while the line stays low. The break length follows the configured character format, so it changes with the data bit count, the parity setting and the stop bit count. All outputs are registered and change one clock after the input that causes them is sampled.

Top module: `rx_event_watch`

## Requirements
- R1: When `rx_valid` is high, `cmp_resume_en` is high and the masked `rx_char` equals `cfg_resume_char`, bit 0 of `irq_status` is set.
- R2: `tx_flow_on` is 1 after reset. A valid matching resume character sets it to 1 and a valid matching stop character (`cfg_stop_char`) clears it to 0. Both changes need `flow_ctl_en` and `cmp_resume_en` to be high. If the two characters are equal, the resume character wins. When `flow_ctl_en` is low, `tx_flow_on` holds its value.
- R3: A valid character that matches `cfg_term_char` while `cmp_term_en` is high sets bit 3 of `irq_status`. The same match drives `eob_push` high for exactly the next cycle.
- R4: When `cmp_resume_en` is low, no resume or stop match has any effect. When `cmp_term_en` is low, the termination compare never fires.
- R5: A compare uses only the low `cfg_data_bits` bits of the received character and of the programmed character. The valid range of `cfg_data_bits` is 5 to 8.
- R6: A break sets bit 1 of `irq_status`. It is declared on the N-th `bit_tick` seen while `rx_line` is continuously low, where N = `cfg_data_bits` + `cfg_parity_en` + (`cfg_two_stop` ? 2 : 1).
- R7: Each low period reports only one break. A new break can be detected only after the break-end event has fired.
- R8: After a break, the first clock that samples `rx_line` high sets bit 2 of `irq_status`.
- R9: Each status bit is sticky. Writing 1 to its bit in `irq_ack` clears it, and an event in the same cycle as the acknowledge leaves the bit set.
- R10: After a synchronous active-low reset, `irq_status` is 0, `eob_push` is 0 and `tx_flow_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_char | input | CHAR_W | Received character, right-aligned |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_char` |
| rx_line | input | 1 | Sampled, synchronised receive line level |
| bit_tick | input | 1 | One-cycle pulse per nominal bit period |
| cfg_data_bits | input | DB_W | Data bits per character (5..8) |
| cfg_parity_en | input | 1 | Parity bit present in the character frame |
| cfg_two_stop | input | 1 | Two stop bits when high, one when low |
| cfg_resume_char | input | CHAR_W | Flow-resume character |
| cfg_stop_char | input | CHAR_W | Flow-stop character |
| cfg_term_char | input | CHAR_W | Block-terminating character |
| flow_ctl_en | input | 1 | In-band flow control enable |
| cmp_resume_en | input | 1 | Resume/stop compare enable |
| cmp_term_en | input | 1 | Termination compare enable |
| irq_ack | input | 4 | Write-1-to-clear acknowledge for each status bit |
| irq_status | output | 4 | Sticky bits: 0 resume, 1 break, 2 break end, 3 termination |
| tx_flow_on | output | 1 | Transmit flow state, 1 = enabled |
| eob_push | output | 1 | One-cycle end-of-block marker strobe |

## Verification
A status bit can be acknowledged in the same cycle that a new event of the same kind arrives, and these two actions collide. The bench first sets the resume bit. It then presents another resume character and writes the acknowledge for that bit in one clock. The bit must still read 1 in the next cycle, and a plain acknowledge afterwards must clear it. The bench also checks that a resume character which is also the termination character raises both bits and the marker together.

// File: rtl/rx_event_pkg.sv
// Shared constants for the receive event detector: status bit positions.
package rx_event_pkg;
    localparam int IRQ_N       = 4;
    localparam int IRQ_RESUME  = 0;
    localparam int IRQ_BREAK   = 1;
    localparam int IRQ_BRK_END = 2;
    localparam int IRQ_TERM    = 3;
endpackage

// File: rtl/char_matcher.sv
// Compares a received character against the programmed resume, stop and
// termination characters. Only the low data_bits bits take part.
// Assumes rx_char is right-aligned and data_bits lies in 5..CHAR_W.
module char_matcher #(
    parameter int CHAR_W = 8,
    localparam int DB_W  = $clog2(CHAR_W + 1)
) (
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_valid,
    input  logic [DB_W-1:0]   data_bits,
    input  logic [CHAR_W-1:0] resume_char,
    input  logic [CHAR_W-1:0] stop_char,
    input  logic [CHAR_W-1:0] term_char,
    input  logic              resume_en,
    input  logic              term_en,
    output logic              resume_hit,
    output logic              stop_hit,
    output logic              term_hit
);
    logic [CHAR_W-1:0] mask;

    // Build the active-bit mask, one bit per character position.
    for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
        assign mask[i] = (DB_W'(i) < data_bits);
    end

    // Qualified comparisons against each programmed character.
    always_comb begin
        resume_hit = rx_valid && resume_en && (((rx_char ^ resume_char) & mask) == '0);
        stop_hit   = rx_valid && resume_en && (((rx_char ^ stop_char) & mask) == '0);
        term_hit   = rx_valid && term_en   && (((rx_char ^ term_char) & mask) == '0);
    end
endmodule

// File: rtl/flow_state.sv
// Holds the transmit flow state. A resume hit sets it and a stop hit clears
// it, both only while in-band flow control is enabled. Resume wins a tie.
module flow_state (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic resume_hit,
    input  logic stop_hit,
    output logic flow_on
);
    // Update the flow state from qualified character hits.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flow_on <= 1'b1;
        else if (flow_en && resume_hit) flow_on <= 1'b1;
        else if (flow_en && stop_hit)   flow_on <= 1'b0;
    end

    assert_flow_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> $stable(flow_on));
endmodule

// File: rtl/break_tracker.sv
// Counts bit ticks while the line is low and flags a break once the count
// reaches the configured frame length. It then waits for the line to return
// high and flags the end of the break. Assumes rx_line is synchronised.
module break_tracker #(
    parameter int CHAR_W = 8,
    localparam int DB_W  = $clog2(CHAR_W + 1),
    localparam int LEN_W = $clog2(CHAR_W + 4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_line,
    input  logic            bit_tick,
    input  logic [DB_W-1:0] data_bits,
    input  logic            parity_en,
    input  logic            two_stop,
    output logic            brk_evt,
    output logic            brk_end_evt
);
    typedef logic [LEN_W-1:0] len_t;

    len_t frame_len;
    len_t low_cnt;
    logic brk_active;

    // Frame length in bits: data, optional parity, one or two stop bits.
    always_comb frame_len = len_t'(data_bits) + len_t'(parity_en) + len_t'(1) + len_t'(two_stop);

    // Event decode from the current count, line level and tick.
    always_comb begin
        brk_evt     = !brk_active && !rx_line && bit_tick && (low_cnt + len_t'(1) == frame_len);
        brk_end_evt = brk_active && rx_line;
    end

    // Low-time counter: cleared by a high line, frozen during a break.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_line)                 low_cnt <= '0;
        else if (bit_tick && !brk_active && !brk_evt) low_cnt <= low_cnt + len_t'(1);
    end

    // Break state: armed again only by the break-end event.
    always_ff @(posedge clk) begin
        if (!rst_n)           brk_active <= 1'b0;
        else if (brk_evt)     brk_active <= 1'b1;
        else if (brk_end_evt) brk_active <= 1'b0;
    end

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |-> $past(!rx_line));
    assert_break_end_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end_evt |-> $past(!rx_line));
endmodule

// File: rtl/irq_sticky.sv
// Sticky status bits: an event sets its bit and a write of 1 to the
// matching acknowledge bit clears it. The event wins a same-cycle tie.
module irq_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ack,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Set or clear one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      status[i] <= 1'b0;
            else if (evt[i]) status[i] <= 1'b1;
            else if (ack[i]) status[i] <= 1'b0;
        end

        assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            status[i] && !ack[i] |=> status[i]);
    end
endmodule

// File: rtl/rx_event_watch.sv
// Top of the receive event detector. It joins the character compare, the
// flow state, the break tracker and the sticky status bits, and it registers
// the end-of-block marker strobe. All outputs are registered.
module rx_event_watch #(
    parameter int CHAR_W = 8,
    localparam int DB_W  = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_valid,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic [DB_W-1:0]   cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_two_stop,
    input  logic [CHAR_W-1:0] cfg_resume_char,
    input  logic [CHAR_W-1:0] cfg_stop_char,
    input  logic [CHAR_W-1:0] cfg_term_char,
    input  logic              flow_ctl_en,
    input  logic              cmp_resume_en,
    input  logic              cmp_term_en,
    input  logic [3:0]        irq_ack,
    output logic [3:0]        irq_status,
    output logic              tx_flow_on,
    output logic              eob_push
);
    import rx_event_pkg::*;

    logic resume_hit, stop_hit, term_hit;
    logic brk_evt, brk_end_evt;
    logic [IRQ_N-1:0] evt;

    char_matcher #(.CHAR_W(CHAR_W)) i_match (
        .rx_char(rx_char), .rx_valid(rx_valid), .data_bits(cfg_data_bits),
        .resume_char(cfg_resume_char), .stop_char(cfg_stop_char),
        .term_char(cfg_term_char), .resume_en(cmp_resume_en), .term_en(cmp_term_en),
        .resume_hit(resume_hit), .stop_hit(stop_hit), .term_hit(term_hit)
    );

    flow_state i_flow (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_ctl_en),
        .resume_hit(resume_hit), .stop_hit(stop_hit), .flow_on(tx_flow_on)
    );

    break_tracker #(.CHAR_W(CHAR_W)) i_brk (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
        .data_bits(cfg_data_bits), .parity_en(cfg_parity_en), .two_stop(cfg_two_stop),
        .brk_evt(brk_evt), .brk_end_evt(brk_end_evt)
    );

    // Gather the event vector in status bit order.
    always_comb begin
        evt              = '0;
        evt[IRQ_RESUME]  = resume_hit;
        evt[IRQ_BREAK]   = brk_evt;
        evt[IRQ_BRK_END] = brk_end_evt;
        evt[IRQ_TERM]    = term_hit;
    end

    irq_sticky #(.N(IRQ_N)) i_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ack(irq_ack), .status(irq_status)
    );

    // One-cycle end-of-block marker after a termination match.
    always_ff @(posedge clk) begin
        if (!rst_n) eob_push <= 1'b0;
        else        eob_push <= term_hit;
    end

    assert_eob_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eob_push |-> irq_status[IRQ_TERM]);
endmodule

// File: tb/test_rx_event_watch.sv
module test_rx_event_watch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_char;
    logic       rx_valid, rx_line, bit_tick;
    logic [3:0] cfg_data_bits;
    logic       cfg_parity_en, cfg_two_stop;
    logic [7:0] cfg_resume_char, cfg_stop_char, cfg_term_char;
    logic       flow_ctl_en, cmp_resume_en, cmp_term_en;
    logic [3:0] irq_ack;
    logic [3:0] irq_status;
    logic       tx_flow_on, eob_push;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_event_watch i_rx_event_watch (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one valid character for one clock; sample after the edge.
    task automatic send(input logic [7:0] c);
        @(negedge clk); rx_char = c; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk); irq_ack = m;
        @(negedge clk); irq_ack = 4'h0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R10 status", irq_status, 0);
        check("R10 flow", tx_flow_on, 1);
        check("R10 eob", eob_push, 0);
    endtask

    task automatic t_flow();
        send(8'h13);
        check("R2 stop clears flow", tx_flow_on, 0);
        send(8'h41);
        check("R1 other char no irq", irq_status, 0);
        send(8'h11);
        check("R1 resume irq", irq_status[0], 1);
        check("R2 resume sets flow", tx_flow_on, 1);
        ack(4'hF);
        flow_ctl_en = 1'b0;
        send(8'h13);
        check("R2 flow frozen when disabled", tx_flow_on, 1);
        flow_ctl_en = 1'b1;
    endtask

    task automatic t_disabled();
        send(8'h13);
        cmp_resume_en = 1'b0; cmp_term_en = 1'b0;
        send(8'h11);
        check("R4 resume compare off irq", irq_status[0], 0);
        check("R4 resume compare off flow", tx_flow_on, 0);
        send(8'h0D);
        check("R4 term compare off irq", irq_status[3], 0);
        check("R4 term compare off eob", eob_push, 0);
        cmp_resume_en = 1'b1; cmp_term_en = 1'b1;
        send(8'h11);
        ack(4'hF);
    endtask

    task automatic t_term();
        send(8'h0D);
        check("R3 term irq", irq_status[3], 1);
        check("R3 eob strobe", eob_push, 1);
        @(negedge clk);
        check("R3 eob one cycle", eob_push, 0);
        ack(4'h8);
        check("R9 ack clears term", irq_status[3], 0);
        cfg_term_char = 8'h11;
        send(8'h11);
        check("R3 shared char both bits", irq_status, 4'h9);
        check("R3 shared char eob", eob_push, 1);
        cfg_term_char = 8'h0D;
        ack(4'hF);
    endtask

    task automatic t_mask();
        cfg_data_bits = 4'd7;
        send(8'h91);
        check("R5 top bit ignored at 7 bits", irq_status[0], 1);
        ack(4'h1);
        cfg_data_bits = 4'd8;
        send(8'h91);
        check("R5 all bits at 8 bits", irq_status[0], 0);
    endtask

    task automatic t_break(input int db, input bit par, input bit two, input string tag);
        int n;
        n = db + par + (two ? 2 : 1);
        cfg_data_bits = 4'(db); cfg_parity_en = par; cfg_two_stop = two;
        @(negedge clk); rx_line = 1'b0;
        tick(n - 1);
        check({tag, " no break before length"}, irq_status[1], 0);
        tick(1);
        check({tag, " break at length"}, irq_status[1], 1);
        ack(4'h2);
        tick(n + 2);
        check("R7 single break per low period", irq_status[1], 0);
        check("R8 no end while low", irq_status[2], 0);
        @(negedge clk); rx_line = 1'b1;
        @(negedge clk);
        check("R8 break end on rise", irq_status[2], 1);
        ack(4'h6);
        cfg_data_bits = 4'd8; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
    endtask

    task automatic t_rearm();
        @(negedge clk); rx_line = 1'b0;
        tick(4);
        @(negedge clk); rx_line = 1'b1;
        @(negedge clk); rx_line = 1'b0;
        tick(8);
        check("R6 high glitch restarts count", irq_status[1], 0);
        tick(1);
        check("R7 rearmed after end", irq_status[1], 1);
        @(negedge clk); rx_line = 1'b1;
        @(negedge clk);
        ack(4'h6);
    endtask

    task automatic t_race();
        send(8'h11);
        @(negedge clk); rx_char = 8'h11; rx_valid = 1'b1; irq_ack = 4'h1;
        @(negedge clk); rx_valid = 1'b0; irq_ack = 4'h0;
        check("R9 event wins over ack", irq_status[0], 1);
        ack(4'h1);
        check("R9 ack clears", irq_status[0], 0);
    endtask

    initial begin
        rst_n = 1'b0; rx_char = '0; rx_valid = 0; rx_line = 1; bit_tick = 0;
        cfg_data_bits = 4'd8; cfg_parity_en = 0; cfg_two_stop = 0;
        cfg_resume_char = 8'h11; cfg_stop_char = 8'h13; cfg_term_char = 8'h0D;
        flow_ctl_en = 1; cmp_resume_en = 1; cmp_term_en = 1; irq_ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flow();
        t_disabled();
        t_term();
        t_mask();
        t_break(5, 0, 0, "R6 5N1");
        t_break(8, 1, 1, "R6 8P2");
        t_break(7, 1, 0, "R6 7P1");
        t_rearm();
        t_race();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule